// File: doc/BRIEF.md
# Serial Transmit Engine with Interrupt Control

This block sends bytes as asynchronous serial frames and combines transmit and receive status into one interrupt request. Software writes an 8-bit control register and a transmit data register through a small write bus. A bit-rate tick from outside sets the pace: the line moves to its next bit on each tick. Each frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit.

Two flags report transmit progress. `tdr_empty` means the data register can take a new byte. `tx_done` means the last frame has ended and nothing is waiting to be sent. When the transmitter is switched on, the line stays idle for at least one full bit time before the first frame. If the transmitter enable is dropped and then raised again while a word is being sent, that word still completes. A ten-bit all-ones preamble then goes out before the next word.

The send-break bit holds the line low once the current frame has ended. When both the transmit and receive enables are low, the serial pin is handed over to a general-purpose output value. The interrupt request is registered. It is the OR of every flag term whose enable is set.

Top module: `sertx_top`

## Requirements
- R1: After reset the control register reads 00h, `tdr_empty` is 1, `tx_done` is 0, `irq` is 0 and `txd` follows `gpio_out`.
- R2: A write with `reg_sel`=0 loads the control register, and `reg_rdata` always shows it. The bit map is: [7] empty-interrupt enable, [6] done-interrupt enable, [5] receive-interrupt enable, [4] idle-interrupt enable, [3] transmit enable, [2] receive enable, [1] receiver wake-up (stored only), [0] send break. A write with `reg_sel`=1 loads the data register.
- R3: A frame is a start bit 0, then data bits 0..7, then a stop bit 1. Each bit lasts one tick period. A byte that is written before the stop bit ends follows with no idle bit.
- R4: After the transmit enable goes from 0 to 1 while the transmitter is idle, the first tick begins one idle bit. A frame can start no earlier than the second tick.
- R5: If the transmit enable is cleared and set again while a frame is being sent, the frame completes. Ten idle bit times of 1 follow, and only then the next queued byte.
- R6: A data write clears `tdr_empty` and `tx_done`. Moving the byte into the shifter sets `tdr_empty`. `tx_done` sets when a frame ends and no byte is waiting.
- R7: One clock after a flag and its enable are both high, `irq` is 1. The pairings are: empty with bit 7, done with bit 6, `rx_ovr` or `rx_full` with bit 5, `rx_idle` with bit 4, and `rx_perr` with `par_irq_en`.
- R8: When every interrupt enable is 0, `irq` stays 0 whatever the flags are.
- R9: While send break is 1 and the transmitter is enabled, `txd` is 0 from the end of the current frame onward. Clearing the bit returns the line to 1.
- R10: When both the transmit and receive enables are 0, `txd` equals `gpio_out`. With either enable set, the idle line is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects transmit data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Control register contents |
| bit_tick | input | 1 | One-clock pulse per bit time |
| rx_ovr | input | 1 | Receive overrun flag |
| rx_full | input | 1 | Receive data full flag |
| rx_idle | input | 1 | Idle line detected flag |
| rx_perr | input | 1 | Parity error flag |
| par_irq_en | input | 1 | Parity interrupt enable |
| gpio_out | input | 1 | Pin value when the serial function is released |
| txd | output | 1 | Serial output |
| tdr_empty | output | 1 | Data register empty flag |
| tx_done | output | 1 | Transmission complete flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The preamble case is the hardest to reach from the ports. It needs a second byte already waiting while the enable drops and rises inside the first frame. The bench waits for `tdr_empty` to show that the first byte has entered the shifter, writes the second byte, and toggles the enable in mid-frame. The scoreboard then expects exactly ten idle samples before the second start bit. The enable delay is handled the same way: the enable write is aligned to a tick, so the expected idle count is exactly two rather than one.

// File: rtl/sertx_pkg.sv
// Package: shared types for the serial transmit engine.
// Assumes: control register is 8 bits; its bit order is decoded by the
// engine, the interrupt merger and software, so it is fixed here.
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DELAY = 3'd1,
        ST_BUSY  = 3'd2,
        ST_PRE   = 3'd3,
        ST_BRK   = 3'd4
    } tx_state_t;

    // Control register, most significant field first.
    typedef struct packed {
        logic empty_ie;
        logic done_ie;
        logic rx_ie;
        logic idle_ie;
        logic tx_en;
        logic rx_en;
        logic rx_wake;
        logic brk;
    } ctrl_t;

endpackage

// File: rtl/sertx_regs.sv
// Module: control and transmit data registers.
// Assumes: DATA_W <= 8; one write per clock; reg_sel 0 = control, 1 = data.
module sertx_regs
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              sel_i,
    input  logic [7:0]        wdata_i,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] tdr_o,
    output logic              data_wr_o,
    output logic              te_rise_o
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] tdr_q;
    ctrl_t             wr_view;

    assign wr_view = ctrl_t'(wdata_i);

    // Register file update on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            tdr_q  <= '0;
        end else if (we_i) begin
            if (!sel_i) ctrl_q <= wr_view;
            else        tdr_q  <= wdata_i[DATA_W-1:0];
        end
    end

    // Strobes for the engine: new data and a 0-to-1 transmit enable write.
    assign data_wr_o = we_i && sel_i;
    assign te_rise_o = we_i && !sel_i && wr_view.tx_en && !ctrl_q.tx_en;
    assign ctrl_o    = ctrl_q;
    assign tdr_o     = tdr_q;

endmodule

// File: rtl/sertx_engine.sv
// Module: tick-paced transmit state machine with shifter and flags.
// Assumes: tick_i is a one-clock pulse; every line change happens on a tick.
// Frame is start 0, DATA_W bits LSB first, stop 1; preamble is a frame of 1s.
module sertx_engine
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              te_i,
    input  logic              sbk_i,
    input  logic              te_rise_i,
    input  logic              data_wr_i,
    input  logic [DATA_W-1:0] tdr_i,
    output logic              line_o,
    output logic              txe_o,
    output logic              tc_o
);

    localparam int FRAME_BITS = DATA_W + 2;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    tx_state_t             state_q, state_d;
    logic [FRAME_BITS-1:0] sh_q, sh_d;
    logic [CNT_W-1:0]      cnt_q, cnt_d;
    logic                  pre_q, pre_d;
    logic                  txe_q, txe_d;
    logic                  tc_q, tc_d;
    logic                  load_now, tc_set;

    // Next-state, shifter and preamble request logic.
    always_comb begin
        state_d  = state_q;
        sh_d     = sh_q;
        cnt_d    = cnt_q;
        pre_d    = pre_q;
        load_now = 1'b0;
        tc_set   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (te_rise_i) begin
                    state_d = ST_DELAY;
                end else if (tick_i && te_i) begin
                    if (sbk_i)       state_d  = ST_BRK;
                    else if (!txe_q) load_now = 1'b1;
                end
            end
            ST_DELAY: begin
                if (!te_i || tick_i) state_d = ST_IDLE;
            end
            ST_BUSY, ST_PRE: begin
                if (te_rise_i) pre_d = 1'b1;
                if (tick_i) begin
                    if (cnt_q == LAST_BIT) begin
                        if (pre_q) begin
                            state_d = ST_PRE;
                            cnt_d   = '0;
                            sh_d    = '1;
                            pre_d   = 1'b0;
                        end else if (te_i && sbk_i) begin
                            state_d = ST_BRK;
                        end else if (te_i && !txe_q) begin
                            load_now = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                            tc_set  = txe_q;
                        end
                    end else begin
                        sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_BRK: begin
                if (!sbk_i || !te_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (load_now) begin
            state_d = ST_BUSY;
            sh_d    = {1'b1, tdr_i, 1'b0};
            cnt_d   = '0;
        end
    end

    // Flag next values: a data write wins over load and completion.
    always_comb begin
        txe_d = data_wr_i ? 1'b0 : (load_now ? 1'b1 : txe_q);
        tc_d  = data_wr_i ? 1'b0 : (tc_set   ? 1'b1 : tc_q);
    end

    // State and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sh_q    <= '1;
            cnt_q   <= '0;
            pre_q   <= 1'b0;
            txe_q   <= 1'b1;
            tc_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            cnt_q   <= cnt_d;
            pre_q   <= pre_d;
            txe_q   <= txe_d;
            tc_q    <= tc_d;
        end
    end

    // Line level before the pin release mux.
    assign line_o = (state_q == ST_BUSY) ? sh_q[0] : (state_q != ST_BRK);
    assign txe_o  = txe_q;
    assign tc_o   = tc_q;

    // R4: the delay state never leads straight into a frame.
    a_r4_no_early_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY) |=> (state_q != ST_BUSY));

    // R6: a load from idle empties the data register and starts a frame.
    a_r6_load_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && tick_i && te_i && !sbk_i && !txe_q && !data_wr_i)
        |=> (txe_q && state_q == ST_BUSY));

    // R6: a data write clears both transmit flags.
    a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_i |=> (!txe_q && !tc_q));

    // R5: a pending preamble follows the last bit of a frame.
    a_r5_preamble_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && pre_q && tick_i && cnt_q == LAST_BIT)
        |=> (state_q == ST_PRE));

    // R9: clearing send break leaves the break state.
    a_r9_break_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BRK && !sbk_i) |=> (state_q != ST_BRK));

endmodule

// File: rtl/sertx_irq.sv
// Module: merges enabled flag terms into one registered interrupt request.
// Assumes: all flag inputs are level signals synchronous to clk.
module sertx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic empty_ie_i,
    input  logic done_ie_i,
    input  logic rx_ie_i,
    input  logic idle_ie_i,
    input  logic par_ie_i,
    input  logic txe_i,
    input  logic tc_i,
    input  logic ovr_i,
    input  logic full_i,
    input  logic idle_i,
    input  logic perr_i,
    output logic irq_o
);

    logic any_term;

    // OR of all enabled flag terms.
    assign any_term = (empty_ie_i && txe_i) || (done_ie_i && tc_i) ||
                      (rx_ie_i && (ovr_i || full_i)) ||
                      (idle_ie_i && idle_i) || (par_ie_i && perr_i);

    // One-clock register on the request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= any_term;
    end

    // R7: an enabled empty flag raises the request one clock later.
    a_r7_empty_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_ie_i && txe_i) |=> irq_o);

    // R7: an enabled receive flag raises the request one clock later.
    a_r7_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie_i && (ovr_i || full_i)) |=> irq_o);

    // R8: with every enable low the request stays low.
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_ie_i || done_ie_i || rx_ie_i || idle_ie_i || par_ie_i) |=> !irq_o);

endmodule

// File: rtl/sertx_top.sv
// Module: serial transmit engine top: registers, engine, interrupt merger
// and pin release mux.
// Assumes: DATA_W <= 8; bit_tick is produced by an external rate generator.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       bit_tick,
    input  logic       rx_ovr,
    input  logic       rx_full,
    input  logic       rx_idle,
    input  logic       rx_perr,
    input  logic       par_irq_en,
    input  logic       gpio_out,
    output logic       txd,
    output logic       tdr_empty,
    output logic       tx_done,
    output logic       irq
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] tdr;
    logic              data_wr, te_rise, line, txe, tc;

    sertx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .sel_i(reg_sel),
        .wdata_i(reg_wdata), .ctrl_o(ctrl), .tdr_o(tdr),
        .data_wr_o(data_wr), .te_rise_o(te_rise)
    );

    sertx_engine #(.DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .tick_i(bit_tick), .te_i(ctrl.tx_en),
        .sbk_i(ctrl.brk), .te_rise_i(te_rise), .data_wr_i(data_wr),
        .tdr_i(tdr), .line_o(line), .txe_o(txe), .tc_o(tc)
    );

    sertx_irq u_irq (
        .clk(clk), .rst_n(rst_n), .empty_ie_i(ctrl.empty_ie),
        .done_ie_i(ctrl.done_ie), .rx_ie_i(ctrl.rx_ie),
        .idle_ie_i(ctrl.idle_ie), .par_ie_i(par_irq_en), .txe_i(txe),
        .tc_i(tc), .ovr_i(rx_ovr), .full_i(rx_full), .idle_i(rx_idle),
        .perr_i(rx_perr), .irq_o(irq)
    );

    // Pin release: the serial function owns the pin only while enabled.
    assign txd       = (!ctrl.tx_en && !ctrl.rx_en) ? gpio_out : line;
    assign reg_rdata = ctrl;
    assign tdr_empty = txe;
    assign tx_done   = tc;

endmodule

// File: tb/sertx_top_tb_top.sv
// Bench: scoreboard. Driver pushes expected bytes and idle-gap counts;
// a monitor decodes txd at mid-bit and compares.
module sertx_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       bit_tick = 1'b0;
    logic       rx_ovr = 0, rx_full = 0, rx_idle = 0, rx_perr = 0, par_irq_en = 0;
    logic       gpio_out = 1'b1;
    logic       txd, tdr_empty, tx_done, irq;

    int n_chk = 0, n_fail = 0, frames_seen = 0;
    int tcnt = 0;
    int exp_d[$];
    int exp_g[$];
    bit mon_en = 1'b0, gap_clr = 1'b0;

    always #2.5 clk = ~clk;

    sertx_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_tick(bit_tick),
        .rx_ovr(rx_ovr), .rx_full(rx_full), .rx_idle(rx_idle),
        .rx_perr(rx_perr), .par_irq_en(par_irq_en), .gpio_out(gpio_out),
        .txd(txd), .tdr_empty(tdr_empty), .tx_done(tx_done), .irq(irq)
    );

    // Bit tick: one clock in eight, changed at the falling edge.
    always @(negedge clk) begin
        bit_tick <= (tcnt == 7);
        tcnt     <= (tcnt == 7) ? 0 : tcnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_tick();
        step();
        while (!bit_tick) step();
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        while (tcnt == 7) step();
        reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        step();
        reg_we = 1'b0;
    endtask

    task automatic push(input int d, input int g);
        exp_d.push_back(d);
        exp_g.push_back(g);
    endtask

    // Monitor: samples mid-bit, decodes frames, compares with the queue.
    initial begin
        bit       in_frame = 1'b0;
        int       nb = 0, gap = 0, start_gap = 0;
        logic [7:0] d = '0;
        forever begin
            @(posedge clk); #1;
            if (bit_tick) begin
                repeat (4) @(posedge clk);
                #1;
                if (!mon_en) begin
                    in_frame = 1'b0; gap = 0;
                end else begin
                    if (gap_clr) begin gap = 0; gap_clr = 1'b0; end
                    if (!in_frame) begin
                        if (txd) gap++;
                        else begin in_frame = 1'b1; nb = 0; start_gap = gap; end
                    end else if (nb < 8) begin
                        d[nb] = txd; nb++;
                    end else begin
                        in_frame = 1'b0;
                        gap = 0;
                        chk(txd == 1'b1, "R3 stop bit", int'(txd), 1);
                        if (exp_d.size() == 0) begin
                            chk(1'b0, "R3 unexpected frame", int'(d), 0);
                        end else begin
                            int ed, eg;
                            ed = exp_d.pop_front();
                            eg = exp_g.pop_front();
                            chk(int'(d) == ed, "R3 frame data", int'(d), ed);
                            if (eg >= 0)
                                chk(start_gap == eg, "R4/R5 idle bits before start", start_gap, eg);
                        end
                        frames_seen++;
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Driver.
    initial begin
        int n;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(reg_rdata == 8'h00, "R1 control reset", reg_rdata, 0);
        chk(tdr_empty == 1'b1 && tx_done == 1'b0, "R1 flags reset", {tdr_empty, tx_done}, 2);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);
        gpio_out = 1'b0; #1;
        chk(txd == 1'b0, "R1/R10 released pin follows gpio", txd, 0);
        gpio_out = 1'b1; #1;
        chk(txd == 1'b1, "R10 released pin follows gpio", txd, 1);

        // R2 readback of a stored-only bit
        wr(0, 8'h02);
        chk(reg_rdata == 8'h02, "R2 control readback", reg_rdata, 2);
        wr(0, 8'h00);

        // R8 flags without enables
        rx_ovr = 1; rx_full = 1; rx_idle = 1; rx_perr = 1;
        step(); step();
        chk(irq == 1'b0, "R8 irq with all enables off", irq, 0);
        rx_ovr = 0; rx_idle = 0; rx_perr = 0;

        // R7 each merged term
        wr(0, 8'h20); step();
        chk(irq == 1'b1, "R7 rx full term", irq, 1);
        rx_full = 0; rx_ovr = 1; step(); step();
        chk(irq == 1'b1, "R7 overrun term", irq, 1);
        rx_ovr = 0; step(); step();
        chk(irq == 1'b0, "R7 rx term drops", irq, 0);
        wr(0, 8'h10); rx_idle = 1; step(); step();
        chk(irq == 1'b1, "R7 idle term", irq, 1);
        rx_idle = 0; wr(0, 8'h00); par_irq_en = 1; rx_perr = 1; step(); step();
        chk(irq == 1'b1, "R7 parity term", irq, 1);
        par_irq_en = 0; rx_perr = 0;
        wr(0, 8'h80); step();
        chk(irq == 1'b1, "R7 empty term", irq, 1);
        wr(0, 8'h00); step();
        chk(irq == 1'b0, "R8 irq clears with enables off", irq, 0);

        // R10 receive enable alone keeps the line high
        wr(0, 8'h04); gpio_out = 1'b0; #1;
        chk(txd == 1'b1, "R10 idle line high when enabled", txd, 1);
        gpio_out = 1'b1;

        // R4 enable delay with data already waiting
        wr(1, 8'h5A);
        chk(tdr_empty == 1'b0, "R6 write clears empty", tdr_empty, 0);
        push(8'h5A, 2);
        wait_tick();
        gap_clr = 1'b1; mon_en = 1'b1;
        wr(0, 8'h0C);
        wait (frames_seen == 1);
        repeat (10) step();
        chk(tx_done == 1'b1 && tdr_empty == 1'b1, "R6 done after frame", {tx_done, tdr_empty}, 3);
        wr(0, 8'h4C); step();
        chk(irq == 1'b1, "R7 done term", irq, 1);
        wr(0, 8'h0C);

        // R3 back-to-back bytes
        wr(1, 8'h01);
        chk(tx_done == 1'b0, "R6 write clears done", tx_done, 0);
        push(8'h01, -1);
        wait (tdr_empty == 1'b1); step();
        wr(1, 8'h80); push(8'h80, 0);
        wait (tdr_empty == 1'b1); step();
        wr(1, 8'hFF); push(8'hFF, 0);
        wait (tdr_empty == 1'b1); step();
        wr(1, 8'h00); push(8'h00, 0);
        wait (frames_seen == 5);

        // R5 preamble after an enable toggle in mid-frame
        wr(1, 8'hA7); push(8'hA7, -1);
        wait (tdr_empty == 1'b1); step();
        wr(1, 8'h5B); push(8'h5B, 10);
        repeat (30) step();
        wr(0, 8'h04);
        wr(0, 8'h0C);
        wait (frames_seen == 7);

        // R9 break after the current frame
        wr(1, 8'h99); push(8'h99, -1);
        wait (tdr_empty == 1'b1); step();
        wr(0, 8'h0D);
        wait (frames_seen == 8);
        mon_en = 1'b0;
        wait_tick(); repeat (4) step();
        chk(txd == 1'b0, "R9 line low after frame", txd, 0);
        repeat (3) wait_tick();
        step();
        chk(txd == 1'b0, "R9 line stays low", txd, 0);
        wr(0, 8'h0C); step();
        chk(txd == 1'b1, "R9 line high after break cleared", txd, 1);

        n = exp_d.size();
        chk(n == 0, "R3 scoreboard drained", n, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule